// File: doc/BRIEF.md
# Accumulator Processor with Interrupt Check Cycle

This block is a small single-accumulator processor core. It steps through instructions held in a synchronous, word-addressed memory. Each instruction is one word. The top four bits hold the operation code and the remaining low bits hold a memory address. Three data operations are provided: copy a memory word into the accumulator, write the accumulator to memory, and add a memory word to the accumulator.

Each instruction takes a fixed sequence of states: fetch, wait for the fetched word, execute, wait for operand data when the operation reads memory, and interrupt check. The interrupt check state samples a level-sensitive request line.

When a request is seen while interrupts are enabled, the core does three things. It copies the program counter and the accumulator into shadow registers. It masks further requests. It then continues fetching at a fixed handler address. A return operation copies the shadow contents back and unmasks requests. Only one level of context is kept, so a request that arrives inside the handler waits until the return.

Top module: `acc_cpu`

## Requirements
- R1: During reset no memory write is issued. After reset the program counter and the accumulator are zero and interrupts are enabled, so the first bus operation is a read of address 0.
- R2: An instruction begins with a read at the program counter. The returned word is taken into the instruction register on the next cycle, and the program counter advances by one, wrapping at the address width.
- R3: Instruction word layout: bits [15:12] are the operation code and bits [11:0] are the address. Code 4'h1 reads the addressed word and places it in the accumulator.
- R4: Code 4'h2 issues a single write cycle to the addressed word, with the accumulator value as write data.
- R5: Code 4'h5 reads the addressed word and adds it to the accumulator, modulo 2^16.
- R6: Every other code except 4'hF is a no-op. It causes no memory access and leaves the accumulator and the program counter unchanged.
- R7: Every instruction ends with one interrupt check cycle that has no bus activity. If no request is taken, the next cycle is the fetch of the following instruction.
- R8: If the request line is high in the check cycle and interrupts are enabled, the core saves the next program counter and the accumulator, masks interrupts, and fetches next at the handler address (default 12'h100).
- R9: While interrupts are masked, a high request line is not taken. It stays pending until it is unmasked.
- R10: Code 4'hF restores the program counter and the accumulator from the shadow registers and unmasks interrupts. A request that is still high is taken in the check cycle of that same instruction.
- R11: The read and write strobes are never both high. Read data is used exactly one cycle after its read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | 1 | Level-sensitive interrupt request |
| mem_rdata | input | 16 | Read data, valid one cycle after mem_rd |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_addr | output | 12 | Word address for read or write |
| mem_wdata | output | 16 | Write data (accumulator) |

## Verification
The assertions take three things for granted. First, the memory returns data exactly one cycle after each read strobe and holds nothing back. Second, the request line changes only between clock edges. Third, the shadow registers are consistent only when the handler is entered through the hardware path. The bench keeps to these conditions. Its memory model registers every read into the data input on the next edge. It drives the request line just after each rising edge. Its handler ends with the return operation. The request line is pulsed briefly, held across a whole handler to force a pending request to be taken right after return, and dropped between instruction boundaries.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    // Operation code field width; the code always sits in the top bits of a word.
    localparam int OPC_W = 4;

    localparam logic [OPC_W-1:0] OPC_LOAD  = 4'h1;
    localparam logic [OPC_W-1:0] OPC_STORE = 4'h2;
    localparam logic [OPC_W-1:0] OPC_ADD   = 4'h5;
    localparam logic [OPC_W-1:0] OPC_RTI   = 4'hF;

    typedef enum logic [2:0] {
        ST_FETCH = 3'd0,
        ST_FWAIT = 3'd1,
        ST_EXEC  = 3'd2,
        ST_EWAIT = 3'd3,
        ST_ICHK  = 3'd4
    } cpu_state_e;

    typedef struct packed {
        logic is_load;
        logic is_store;
        logic is_add;
        logic is_rti;
    } op_dec_t;

    typedef struct packed {
        logic fetch_rd;     // read at program counter
        logic ir_load;      // capture fetched word, advance pc
        logic exec_rd;      // operand read at address field
        logic exec_wr;      // write accumulator at address field
        logic ac_load;      // capture operand into accumulator
        logic ctx_restore;  // return from handler
        logic ctx_save;     // enter handler
    } cpu_ctl_t;

    function automatic op_dec_t decode_op(input logic [OPC_W-1:0] op);
        op_dec_t d;
        d          = '0;
        d.is_load  = (op == OPC_LOAD);
        d.is_store = (op == OPC_STORE);
        d.is_add   = (op == OPC_ADD);
        d.is_rti   = (op == OPC_RTI);
        return d;
    endfunction

endpackage

// File: rtl/acc_cpu_decode.sv
module acc_cpu_decode
    import acc_cpu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_dec_t          dec
);

    always_comb begin
        dec = decode_op(opcode);
    end

endmodule

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
    import acc_cpu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       irq,
    input  logic       ie,
    input  op_dec_t    dec,
    output cpu_state_e state,
    output cpu_ctl_t   ctl
);

    cpu_state_e state_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= ST_FETCH;
        else     state <= state_nxt;
    end

    always_comb begin
        ctl       = '0;
        state_nxt = state;
        case (state)
            ST_FETCH: begin
                ctl.fetch_rd = 1'b1;
                state_nxt    = ST_FWAIT;
            end
            ST_FWAIT: begin
                ctl.ir_load = 1'b1;
                state_nxt   = ST_EXEC;
            end
            ST_EXEC: begin
                if (dec.is_load || dec.is_add) begin
                    ctl.exec_rd = 1'b1;
                    state_nxt   = ST_EWAIT;
                end else begin
                    ctl.exec_wr     = dec.is_store;
                    ctl.ctx_restore = dec.is_rti;
                    state_nxt       = ST_ICHK;
                end
            end
            ST_EWAIT: begin
                ctl.ac_load = 1'b1;
                state_nxt   = ST_ICHK;
            end
            ST_ICHK: begin
                ctl.ctx_save = irq & ie;
                state_nxt    = ST_FETCH;
            end
            default: state_nxt = ST_FETCH;
        endcase
    end

    // R11: the fetched word is consumed only in the cycle after a fetch read
    assert_fwait_after_fetch_R11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FWAIT) |-> ($past(state) == ST_FETCH));

    // R7: the check cycle always closes an execute step
    assert_ichk_after_exec_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ICHK) |-> ($past(state) == ST_EXEC || $past(state) == ST_EWAIT));

    // R7: after the check cycle the next state is always a fetch
    assert_fetch_after_ichk_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ICHK) |=> (state == ST_FETCH));

endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int WORD_W = OPC_W + ADDR_W,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  cpu_ctl_t          ctl,
    input  logic              ac_accumulate,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic [OPC_W-1:0]  opcode,
    output logic              ie,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata
);

    localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);

    logic [ADDR_W-1:0] pc;
    logic [WORD_W-1:0] ir;
    logic [WORD_W-1:0] ac;
    logic [ADDR_W-1:0] shadow_pc;
    logic [WORD_W-1:0] shadow_ac;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc        <= '0;
            ir        <= '0;
            ac        <= '0;
            ie        <= 1'b1;
            shadow_pc <= '0;
            shadow_ac <= '0;
        end else begin
            if (ctl.ir_load) begin
                ir <= mem_rdata;
                pc <= pc + PC_STEP;
            end
            if (ctl.ac_load) begin
                ac <= ac_accumulate ? (ac + mem_rdata) : mem_rdata;
            end
            if (ctl.ctx_restore) begin
                pc <= shadow_pc;
                ac <= shadow_ac;
                ie <= 1'b1;
            end
            if (ctl.ctx_save) begin
                shadow_pc <= pc;
                shadow_ac <= ac;
                pc        <= HANDLER_ADDR;
                ie        <= 1'b0;
            end
        end
    end

    assign opcode    = ir[WORD_W-1 -: OPC_W];
    assign mem_addr  = ctl.fetch_rd ? pc : ir[ADDR_W-1:0];
    assign mem_wdata = ac;

    // R2: each fetch advances the program counter by one
    assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
        ctl.ir_load |=> (pc == $past(pc) + PC_STEP));

    // R8: handler entry saves context, masks and redirects
    assert_handler_entry_R8: assert property (@(posedge clk) disable iff (rst)
        ctl.ctx_save |=> (pc == HANDLER_ADDR && !ie &&
                          shadow_pc == $past(pc) && shadow_ac == $past(ac)));

    // R9: a masked core stays masked until a return
    assert_mask_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (!ie && !ctl.ctx_restore) |=> !ie);

    // R10: return restores both registers and unmasks
    assert_restore_R10: assert property (@(posedge clk) disable iff (rst)
        ctl.ctx_restore |=> (pc == $past(shadow_pc) && ac == $past(shadow_ac) && ie));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter logic [ADDR_W-1:0] HANDLER_ADDR = 12'h100
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      irq,
    input  logic [OPC_W+ADDR_W-1:0]   mem_rdata,
    output logic                      mem_rd,
    output logic                      mem_wr,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [OPC_W+ADDR_W-1:0]   mem_wdata
);

    localparam int WORD_W = OPC_W + ADDR_W;

    cpu_state_e        state;
    cpu_ctl_t          ctl;
    op_dec_t           dec;
    logic [OPC_W-1:0]  opcode;
    logic              ie;

    acc_cpu_decode u_decode (
        .opcode (opcode),
        .dec    (dec)
    );

    acc_cpu_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .irq   (irq),
        .ie    (ie),
        .dec   (dec),
        .state (state),
        .ctl   (ctl)
    );

    acc_cpu_dp #(
        .ADDR_W       (ADDR_W),
        .WORD_W       (WORD_W),
        .HANDLER_ADDR (HANDLER_ADDR)
    ) u_dp (
        .clk           (clk),
        .rst           (rst),
        .ctl           (ctl),
        .ac_accumulate (dec.is_add),
        .mem_rdata     (mem_rdata),
        .opcode        (opcode),
        .ie            (ie),
        .mem_addr      (mem_addr),
        .mem_wdata     (mem_wdata)
    );

    assign mem_rd = ctl.fetch_rd | ctl.exec_rd;
    assign mem_wr = ctl.exec_wr;

    // R11: read and write strobes are exclusive
    assert_rd_wr_excl_R11: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R7: no bus activity in the interrupt check cycle
    assert_ichk_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ICHK) |-> (!mem_rd && !mem_wr));

endmodule

// File: tb/acc_cpu_tb.sv
`timescale 1ns/1ps
module acc_cpu_tb;

    localparam logic [11:0] HANDLER = 12'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        irq = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        mem_rd, mem_wr;
    logic [11:0] mem_addr;
    logic [15:0] mem_wdata;

    always #2 clk = ~clk;

    acc_cpu u_dut (
        .clk       (clk),
        .rst       (rst),
        .irq       (irq),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // bench memory, one cycle read latency
    logic [15:0] mem   [0:1023];
    logic [15:0] m_mem [0:1023];

    always @(posedge clk) begin
        if (mem_wr) mem[mem_addr[9:0]] <= mem_wdata;
        if (mem_rd) mem_rdata <= mem[mem_addr[9:0]];
    end

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] enc(input logic [3:0] op, input logic [11:0] a);
        return {op, a};
    endfunction

    task automatic put(input int a, input logic [15:0] w);
        mem[a]   = w;
        m_mem[a] = w;
    endtask

    // ---------------- behavioural reference model ----------------
    // kinds: 0 idle, 1 read, 2 write, 3 check cycle (idle)
    int          q_kind [$];
    logic [11:0] q_addr [$];
    logic [15:0] q_data [$];
    string       q_tag  [$];

    logic [11:0] m_pc = '0;
    logic [15:0] m_ac = '0;
    bit          m_ie = 1'b1;
    logic [11:0] s_pc = '0;
    logic [15:0] s_ac = '0;
    int          m_takes = 0;
    bit          model_on = 1'b0;

    task automatic push(input int k, input logic [11:0] a, input logic [15:0] d, input string t);
        q_kind.push_back(k);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(t);
    endtask

    task automatic gen_instr();
        logic [15:0] w;
        logic [3:0]  op;
        logic [11:0] a;
        w  = m_mem[m_pc[9:0]];
        op = w[15:12];
        a  = w[11:0];
        push(1, m_pc, 16'h0, (m_pc == HANDLER) ? "R8" : "R2");
        push(0, 12'h0, 16'h0, "R11");
        m_pc = m_pc + 12'd1;
        case (op)
            4'h1: begin
                push(1, a, 16'h0, "R3");
                push(0, 12'h0, 16'h0, "R11");
                m_ac = m_mem[a[9:0]];
            end
            4'h5: begin
                push(1, a, 16'h0, "R5");
                push(0, 12'h0, 16'h0, "R11");
                m_ac = m_ac + m_mem[a[9:0]];
            end
            4'h2: begin
                push(2, a, m_ac, "R4");
                m_mem[a[9:0]] = m_ac;
            end
            4'hF: begin
                push(0, 12'h0, 16'h0, "R10");
                m_pc = s_pc;
                m_ac = s_ac;
                m_ie = 1'b1;
            end
            default: push(0, 12'h0, 16'h0, "R6");
        endcase
        push(3, 12'h0, 16'h0, "R7");
    endtask

    always @(negedge clk) begin
        if (model_on) begin
            int          k;
            logic [11:0] a;
            logic [15:0] d;
            string       t;
            logic [29:0] act, exp;
            if (q_kind.size() == 0) gen_instr();
            k = q_kind.pop_front();
            a = q_addr.pop_front();
            d = q_data.pop_front();
            t = q_tag.pop_front();
            exp = {k == 1, k == 2, (k == 1 || k == 2) ? a : 12'h0, (k == 2) ? d : 16'h0};
            act = {mem_rd, mem_wr, (mem_rd || mem_wr) ? mem_addr : 12'h0,
                   mem_wr ? mem_wdata : 16'h0};
            chk(act == exp, t, "bus {rd,wr,addr,wdata}", 32'(act), 32'(exp));
            if (k == 3 && irq && m_ie) begin
                s_pc = m_pc;
                s_ac = m_ac;
                m_pc = HANDLER;
                m_ie = 1'b0;
                m_takes++;
            end
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        for (int i = 0; i < 1024; i++) put(i, 16'h0000);
        // main program
        put(0, enc(4'h1, 12'h200));
        put(1, enc(4'h5, 12'h201));
        put(2, enc(4'h2, 12'h202));
        put(3, enc(4'h5, 12'h201));
        put(4, enc(4'h2, 12'h203));
        put(5, enc(4'h3, 12'h204));   // unused code aimed at a data word
        put(6, enc(4'h5, 12'h205));
        put(7, enc(4'h2, 12'h206));
        for (int i = 0; i < 32; i++) begin
            put(8 + 2*i, enc(4'h5, 12'h201));
            put(9 + 2*i, enc(4'h2, 12'(12'h210 + i)));
        end
        // handler: bump counter, clobber AC, return
        put(12'h100, enc(4'h1, 12'h300));
        put(12'h101, enc(4'h5, 12'h301));
        put(12'h102, enc(4'h2, 12'h300));
        put(12'h103, enc(4'h1, 12'h302));
        put(12'h104, enc(4'hF, 12'h000));
        // data
        put(12'h200, 16'h1234);
        put(12'h201, 16'h0011);
        put(12'h204, 16'hA5A5);
        put(12'h205, 16'hFFF0);
        put(12'h300, 16'h0000);
        put(12'h301, 16'h0001);
        put(12'h302, 16'hBEEF);

        rst = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(mem_wr == 1'b0, "R1", "no write in reset", 32'(mem_wr), 32'h0);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        model_on = 1'b1;
        @(negedge clk);
        chk(mem_rd && mem_addr == 12'h000, "R1", "first fetch at 0",
            {19'h0, mem_rd, mem_addr}, {19'h0, 1'b1, 12'h000});

        repeat (40) @(posedge clk);
        #1 irq = 1'b1;                       // short pulse
        repeat (3) @(posedge clk);
        #1 irq = 1'b0;
        repeat (80) @(posedge clk);
        #1 irq = 1'b1;                       // held across the handler
        repeat (45) @(posedge clk);
        #1 irq = 1'b0;
        repeat (100) @(posedge clk);
        #1 irq = 1'b1;
        repeat (2) @(posedge clk);
        #1 irq = 1'b0;
        repeat (400) @(posedge clk);
        @(negedge clk);
        model_on = 1'b0;
        repeat (3) @(posedge clk);

        // end-state checks (fixed values from the requirements)
        chk(mem[12'h202] == 16'h1245, "R5", "sum at 0x202", 32'(mem[12'h202]), 32'h1245);
        chk(mem[12'h203] == 16'h1256, "R4", "store at 0x203", 32'(mem[12'h203]), 32'h1256);
        chk(mem[12'h204] == 16'hA5A5, "R6", "unused code left 0x204", 32'(mem[12'h204]), 32'hA5A5);
        chk(mem[12'h206] == 16'h1246, "R5", "wrapped sum at 0x206", 32'(mem[12'h206]), 32'h1246);
        chk(mem[12'h300] == 16'(m_takes), "R9", "handler entries", 32'(mem[12'h300]), 32'(m_takes));
        chk(m_takes >= 3, "R10", "pending request retaken", 32'(m_takes), 32'd3);
        for (int i = 12'h210; i < 12'h230; i++)
            chk(mem[i] == m_mem[i], "R10", "context kept across handler",
                32'(mem[i]), 32'(m_mem[i]));

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule